// File: doc/BRIEF.md
# RV64 Integer Multiply-Divide Unit

This execution unit performs the integer multiply, divide and remainder operations of a 64-bit RISC-V core. Each operation arrives as a single-cycle request carrying two 64-bit operands, a 4-bit operation code and a destination tag. The result returns later on a valid strobe together with the same tag. The 32-bit word forms share the 64-bit datapath. They read only the low halves of the operands, and the low 32 bits of their result are sign-extended to 64.

Multiplies run through a fixed-latency pipeline and may be issued back to back. Divides and remainders run on an iterative restoring radix-2 engine that retires one quotient bit per clock: 32 steps for word forms and 64 for full-width forms. While the engine runs, `busy` is high and the unit ignores new requests of either kind, so a multiply and a divide can never finish in the same cycle. A flush drops every operation still in flight. The division corner cases (divisor zero, most negative value divided by -1) follow the RISC-V rules at the width of the operation.

Top module: `rv_muldiv`

## Requirements
- R1: Operation codes are: 0 low product, 1 high signed×signed, 2 high signed×unsigned, 3 high unsigned×unsigned, 4 word multiply, 8 signed divide, 9 unsigned divide, 10 signed remainder, 11 unsigned remainder, 12 to 15 the same four as word forms (bit 3 selects divide, bit 2 word, bit 1 remainder, bit 0 unsigned). Code 0 returns the low 64 bits of the product.
- R2: Codes 1, 2 and 3 return bits 127:64 of the 128-bit product, with operand A signed for codes 1 and 2 and operand B signed only for code 1.
- R3: Code 4 multiplies the low 32 bits of each operand and returns the low 32 bits of the product sign-extended to 64.
- R4: A multiply accepted at a clock edge raises `out_valid` with its result and tag after the third edge, counting the accepting edge as the first. Multiplies on consecutive cycles each produce a result.
- R5: Codes 8 to 11 return the truncating 64-bit quotient or remainder. The remainder takes the sign of the dividend.
- R6: Codes 12 to 15 operate on the low 32 bits and return the 32-bit result sign-extended from bit 31, for the unsigned forms as well.
- R7: With a zero divisor at the operation's width, the quotient is all ones and the remainder is the dividend (word forms: sign-extended low 32 bits).
- R8: With the most negative dividend and a divisor of -1 at the operation's width, the quotient is the dividend and the remainder is zero.
- R9: A divide accepted at edge k keeps `busy` high after edges k through k+N-1 and presents its result after edge k+N, where N is 32 for word forms and 64 otherwise.
- R10: A request presented while `busy` is high is dropped: it produces no result and does not disturb the running divide.
- R11: `flush` sampled high at an edge removes all in-flight work. From that edge on, no result from earlier requests appears and `busy` falls, and a request presented with `flush` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight operations |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_a | input | 64 | Operand A (dividend / multiplicand) |
| in_b | input | 64 | Operand B (divisor / multiplier) |
| in_tag | input | TAG_W | Destination tag |
| busy | output | 1 | Divide engine running; requests are dropped |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Result |
| out_tag | output | TAG_W | Tag of the result |

## Verification
The bench builds the unit with its defaults: XLEN 64, TAG_W 6 and a three-stage multiplier. This exercises the real word/full split at bit 31 and the 64-step divide. The 6-bit tag lets every request in a burst of back-to-back multiplies carry a distinct tag, so a result that lands in the wrong cycle or with the wrong tag is caught. At the full 64-bit width the extremes are reachable: the most negative value at both 32 and 64 bits, all-ones divisors, and zero divisors. A flush can also be placed at every pipeline depth.

// File: rtl/rv_muldiv_pkg.sv
package rv_muldiv_pkg;

  typedef enum logic [3:0] {
    OP_MUL    = 4'd0,
    OP_MULH   = 4'd1,
    OP_MULHSU = 4'd2,
    OP_MULHU  = 4'd3,
    OP_MULW   = 4'd4,
    OP_DIV    = 4'd8,
    OP_DIVU   = 4'd9,
    OP_REM    = 4'd10,
    OP_REMU   = 4'd11,
    OP_DIVW   = 4'd12,
    OP_DIVUW  = 4'd13,
    OP_REMW   = 4'd14,
    OP_REMUW  = 4'd15
  } md_op_e;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_WORD = 2'd2
  } mul_sel_e;

  // divide-op field positions inside the operation code
  localparam int unsigned OPB_DIV  = 3;
  localparam int unsigned OPB_WORD = 2;
  localparam int unsigned OPB_REM  = 1;
  localparam int unsigned OPB_UNS  = 0;

endpackage

// File: rtl/rv_md_mul.sv
module rv_md_mul
  import rv_muldiv_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [TAG_W-1:0] tag,
  output logic             res_valid,
  output logic [XLEN-1:0]  res_data,
  output logic [TAG_W-1:0] res_tag
);

  localparam int unsigned PW    = 2 * XLEN + 2;
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned DEPTH = LAT - 1;

  // operand stage
  logic                   s0_v, s0_v_n;
  logic signed [XLEN:0]   s0_a, s0_b;
  mul_sel_e               s0_sel;
  logic [TAG_W-1:0]       s0_tag;
  logic                   sgn_a, sgn_b;
  mul_sel_e               sel_n;

  always_comb begin
    sgn_a  = (op == OP_MULH) || (op == OP_MULHSU);
    sgn_b  = (op == OP_MULH);
    if (op[OPB_WORD])       sel_n = SEL_WORD;
    else if (op[1:0] == 2'd0) sel_n = SEL_LOW;
    else                    sel_n = SEL_HIGH;
    s0_v_n = start && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s0_v <= 1'b0;
    else        s0_v <= s0_v_n;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      s0_a   <= {sgn_a & a[XLEN-1], a};
      s0_b   <= {sgn_b & b[XLEN-1], b};
      s0_sel <= sel_n;
      s0_tag <= tag;
    end
  end

  // product and result selection
  logic signed [PW-1:0] prod;
  logic [XLEN-1:0]      sel_res;

  always_comb begin
    prod = s0_a * s0_b;
    case (s0_sel)
      SEL_HIGH: sel_res = prod[2*XLEN-1:XLEN];
      SEL_WORD: sel_res = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
      default:  sel_res = prod[XLEN-1:0];
    endcase
  end

  // delay pipeline, one register per remaining stage
  logic             pv   [DEPTH];
  logic [XLEN-1:0]  pd   [DEPTH];
  logic [TAG_W-1:0] pt   [DEPTH];
  logic             pv_i [DEPTH];
  logic [XLEN-1:0]  pd_i [DEPTH];
  logic [TAG_W-1:0] pt_i [DEPTH];

  always_comb begin
    pv_i[0] = s0_v;
    pd_i[0] = sel_res;
    pt_i[0] = s0_tag;
    for (int i = 1; i < DEPTH; i++) begin
      pv_i[i] = pv[i-1];
      pd_i[i] = pd[i-1];
      pt_i[i] = pt[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic v_n;
    always_comb v_n = pv_i[g] && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv[g] <= 1'b0;
      else        pv[g] <= v_n;
    end

    always_ff @(posedge clk) begin
      if (pv_i[g]) begin
        pd[g] <= pd_i[g];
        pt[g] <= pt_i[g];
      end
    end
  end

  assign res_valid = pv[DEPTH-1];
  assign res_data  = pd[DEPTH-1];
  assign res_tag   = pt[DEPTH-1];

  // R11: nothing emerges the cycle after a flush
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid);

endmodule

// File: rtl/rv_md_div.sv
module rv_md_div
  import rv_muldiv_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [TAG_W-1:0] tag,
  output logic             busy,
  output logic             res_valid,
  output logic [XLEN-1:0]  res_data,
  output logic [TAG_W-1:0] res_tag
);

  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned CNT_W = $clog2(XLEN);

  // iteration state
  logic              active, active_n;
  logic              done, done_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [XLEN-1:0]   rem, rem_n;
  logic [XLEN-1:0]   quo, quo_n;

  // per-operation attributes, loaded on start
  logic [XLEN-1:0]   dsr, dvd;
  logic              f_word, f_rem, f_sa, f_sb, f_bz, f_sgn;
  logic [TAG_W-1:0]  f_tag;

  // operand preparation
  logic              word, sgn, sa, sb;
  logic [XLEN-1:0]   a_w, b_w, mag_a, mag_b, quo_ld;

  always_comb begin
    word = op[OPB_WORD];
    sgn  = !op[OPB_UNS];
    if (word) begin
      a_w = sgn ? {{HALF{a[HALF-1]}}, a[HALF-1:0]} : {{HALF{1'b0}}, a[HALF-1:0]};
      b_w = sgn ? {{HALF{b[HALF-1]}}, b[HALF-1:0]} : {{HALF{1'b0}}, b[HALF-1:0]};
    end else begin
      a_w = a;
      b_w = b;
    end
    sa     = sgn && a_w[XLEN-1];
    sb     = sgn && b_w[XLEN-1];
    mag_a  = sa ? -a_w : a_w;
    mag_b  = sb ? -b_w : b_w;
    quo_ld = word ? (mag_a << HALF) : mag_a;
  end

  // one restoring step
  logic [XLEN:0] rem_sh;
  logic          fits;

  always_comb begin
    rem_sh   = {rem, quo[XLEN-1]};
    fits     = rem_sh >= {1'b0, dsr};
    active_n = active;
    done_n   = 1'b0;
    cnt_n    = cnt;
    rem_n    = rem;
    quo_n    = quo;
    if (flush) begin
      active_n = 1'b0;
    end else if (start) begin
      active_n = 1'b1;
      cnt_n    = word ? CNT_W'(HALF - 1) : CNT_W'(XLEN - 1);
      rem_n    = '0;
      quo_n    = quo_ld;
    end else if (active) begin
      rem_n = fits ? XLEN'(rem_sh - {1'b0, dsr}) : rem_sh[XLEN-1:0];
      quo_n = {quo[XLEN-2:0], fits};
      cnt_n = cnt - 1'b1;
      if (cnt == '0) begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      active <= active_n;
      done   <= done_n;
    end
  end

  always_ff @(posedge clk) begin
    if (start || active) begin
      cnt <= cnt_n;
      rem <= rem_n;
      quo <= quo_n;
    end
    if (start) begin
      dsr    <= mag_b;
      dvd    <= a_w;
      f_word <= word;
      f_rem  <= op[OPB_REM];
      f_sgn  <= sgn;
      f_sa   <= sa;
      f_sb   <= sb;
      f_bz   <= (b_w == '0);
      f_tag  <= tag;
    end
  end

  // result fix-up
  logic [XLEN-1:0] q_s, r_s, val;

  always_comb begin
    q_s = (f_sgn && (f_sa ^ f_sb) && !f_bz) ? -quo : quo;
    r_s = f_sa ? -rem : rem;
    if (f_rem) val = f_bz ? dvd : r_s;
    else       val = f_bz ? '1  : q_s;
    res_data = f_word ? {{HALF{val[HALF-1]}}, val[HALF-1:0]} : val;
  end

  assign busy      = active;
  assign res_valid = done;
  assign res_tag   = f_tag;

  // R5: partial remainder stays below the divisor throughout
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dsr != '0) |-> (rem < dsr));

  // R9: word operations never load more than HALF steps
  p_word_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && f_word) |-> (cnt < CNT_W'(HALF)));

  // R11: flush stops the engine and suppresses completion
  p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!active && !done));

endmodule

// File: rtl/rv_muldiv.sv
module rv_muldiv
  import rv_muldiv_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned MUL_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [3:0]       in_op,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             busy,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_data,
  output logic [TAG_W-1:0] out_tag
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  logic             div_busy;
  logic             acc, mul_go, div_go;
  logic             mul_v, div_v;
  logic [XLEN-1:0]  mul_d, div_d;
  logic [TAG_W-1:0] mul_t, div_t;

  always_comb begin
    acc    = in_valid && !div_busy && !flush;
    div_go = acc && in_op[OPB_DIV];
    mul_go = acc && !in_op[OPB_DIV];
  end

  rv_md_mul #(.XLEN(XLEN), .TAG_W(TAG_W), .LAT(MUL_LAT)) u_mul (
    .clk       (clk),
    .rst_n     (rst_sn),
    .flush     (flush),
    .start     (mul_go),
    .op        (in_op),
    .a         (in_a),
    .b         (in_b),
    .tag       (in_tag),
    .res_valid (mul_v),
    .res_data  (mul_d),
    .res_tag   (mul_t)
  );

  rv_md_div #(.XLEN(XLEN), .TAG_W(TAG_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_sn),
    .flush     (flush),
    .start     (div_go),
    .op        (in_op),
    .a         (in_a),
    .b         (in_b),
    .tag       (in_tag),
    .busy      (div_busy),
    .res_valid (div_v),
    .res_data  (div_d),
    .res_tag   (div_t)
  );

  always_comb begin
    busy      = div_busy;
    out_valid = mul_v || div_v;
    out_data  = div_v ? div_d : mul_d;
    out_tag   = div_v ? div_t : mul_t;
  end

  // R10: gating on busy keeps the two result sources apart
  p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mul_v && div_v));

  // R9: an unflushed divide that stops running delivers its result
  p_busy_fall_result_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(busy) && !$past(flush)) |-> out_valid);

endmodule

// File: tb/sim_rv_muldiv.sv
`timescale 1ns/1ps
module sim_rv_muldiv;

  localparam int TAG_W = 6;
  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic             in_valid = 1'b0;
  logic [3:0]       in_op = '0;
  logic [63:0]      in_a = '0, in_b = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             busy, out_valid;
  logic [63:0]      out_data;
  logic [TAG_W-1:0] out_tag;

  rv_muldiv u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ref_res(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic [127:0] ea, eb, p;
    logic [31:0]  a32, b32, t32;
    logic [63:0]  r;
    bit           ovf64, ovf32;
    a32 = a[31:0];
    b32 = b[31:0];
    ovf64 = (a == MIN64) && (b == '1);
    ovf32 = (a32 == 32'h8000_0000) && (b32 == '1);
    r = '0;
    case (op)
      4'd0: r = a * b;
      4'd1: begin ea = {{64{a[63]}}, a}; eb = {{64{b[63]}}, b}; p = ea * eb; r = p[127:64]; end
      4'd2: begin ea = {{64{a[63]}}, a}; eb = {64'b0, b};       p = ea * eb; r = p[127:64]; end
      4'd3: begin ea = {64'b0, a};       eb = {64'b0, b};       p = ea * eb; r = p[127:64]; end
      4'd4: begin t32 = a32 * b32; r = sx32(t32); end
      4'd8:  r = (b == 0) ? '1 : ovf64 ? a : 64'($signed(a) / $signed(b));
      4'd9:  r = (b == 0) ? '1 : a / b;
      4'd10: r = (b == 0) ? a : ovf64 ? 64'd0 : 64'($signed(a) % $signed(b));
      4'd11: r = (b == 0) ? a : a % b;
      4'd12: begin t32 = (b32 == 0) ? '1 : ovf32 ? a32 : 32'($signed(a32) / $signed(b32)); r = sx32(t32); end
      4'd13: begin t32 = (b32 == 0) ? '1 : a32 / b32; r = sx32(t32); end
      4'd14: begin t32 = (b32 == 0) ? a32 : ovf32 ? 32'd0 : 32'($signed(a32) % $signed(b32)); r = sx32(t32); end
      4'd15: begin t32 = (b32 == 0) ? a32 : a32 % b32; r = sx32(t32); end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    bit word = op[2];
    bit bz   = word ? (b[31:0] == 0) : (b == 0);
    bit ov   = word ? (a[31:0] == 32'h8000_0000 && b[31:0] == '1) : (a == MIN64 && b == '1);
    if (!op[3]) begin
      if (op == 4'd0) return "R1 R4";
      if (op == 4'd4) return "R3 R4";
      return "R2 R4";
    end
    if (bz) return "R7 R9";
    if (ov && !op[0]) return "R8 R9";
    return word ? "R6 R9" : "R5 R9";
  endfunction

  // behavioural reference: expectations keyed by edge count
  int           cyc = 0;
  logic [63:0]  exp_d [int];
  logic [TAG_W-1:0] exp_t [int];
  string        exp_r [int];
  bit           div_on = 0;
  int           div_k = 0, div_n = 0;
  int           rst_edges = 0;

  always @(posedge clk) begin
    int key;
    cyc++;
    if (!rst_n) begin
      exp_d.delete(); exp_t.delete(); exp_r.delete();
      div_on = 0;
      rst_edges = 0;
    end else begin
      rst_edges++;
      if (flush) begin
        foreach (exp_d[k]) if (k >= cyc) begin exp_d.delete(k); exp_t.delete(k); exp_r.delete(k); end
        div_on = 0;
      end else if (in_valid && rst_edges > 2) begin
        if (!(div_on && cyc >= div_k + 1 && cyc <= div_k + div_n)) begin
          if (in_op[3]) begin
            div_on = 1; div_k = cyc; div_n = in_op[2] ? 32 : 64;
            key = cyc + div_n;
          end else begin
            key = cyc + 2;
          end
          exp_d[key] = ref_res(in_op, in_a, in_b);
          exp_t[key] = in_tag;
          exp_r[key] = req_of(in_op, in_a, in_b);
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit exp_busy;
    if (rst_n && !done_flag) begin
      exp_busy = div_on && cyc >= div_k && cyc <= div_k + div_n - 1;
      tests++;
      if (busy !== exp_busy) begin
        fails++;
        $display("FAIL R9 busy cyc=%0d actual=%b expected=%b", cyc, busy, exp_busy);
      end
      tests++;
      if (exp_d.exists(cyc)) begin
        if (out_valid !== 1'b1 || out_data !== exp_d[cyc] || out_tag !== exp_t[cyc]) begin
          fails++;
          $display("FAIL %s cyc=%0d actual=%b/%h/%0d expected=1/%h/%0d", exp_r[cyc], cyc,
                   out_valid, out_data, out_tag, exp_d[cyc], exp_t[cyc]);
        end
        exp_d.delete(cyc); exp_t.delete(cyc); exp_r.delete(cyc);
      end else if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R10 R11 spurious result cyc=%0d actual=%b/%h expected=0", cyc, out_valid, out_data);
      end
    end
  end

  task automatic drive(logic [3:0] op, logic [63:0] a, logic [63:0] b, logic [TAG_W-1:0] t);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = t;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return 64'd0;
      1: return '1;
      2: return MIN64;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'h0000_0000_FFFF_FFFF;
      5: return 64'($urandom % 50);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic logic [3:0] pick_op();
    int s = $urandom % 13;
    return (s < 5) ? 4'(s) : 4'(s + 3);
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    tests++;
    if (out_valid !== 1'b0 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset state actual=%b/%b expected=0/0", out_valid, busy);
    end

    // R1 R2 R3 R4: each multiply form, then a back-to-back burst
    drive(4'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 6'd1);
    drive(4'd1, MIN64, MIN64, 6'd2);
    drive(4'd1, '1, 64'd7, 6'd3);
    drive(4'd2, '1, '1, 6'd4);
    drive(4'd3, '1, '1, 6'd5);
    drive(4'd4, 64'hFFFF_FFFF_0001_0000, 64'h1234_0000_0001_0000, 6'd6);
    drive(4'd4, 64'h0000_0000_7FFF_FFFF, 64'd2, 6'd7);
    idle(5);

    // R5 R6: divides of each width
    drive(4'd8, -64'sd100, 64'd7, 6'd10);   idle(70);
    drive(4'd10, -64'sd100, 64'd7, 6'd11);  idle(70);
    drive(4'd9, '1, 64'd3, 6'd12);          idle(70);
    drive(4'd11, '1, 64'd10, 6'd13);        idle(70);
    drive(4'd12, 64'h1234_5678_FFFF_FF9C, 64'd7, 6'd14); idle(36);
    drive(4'd13, 64'h0000_0000_FFFF_FFFF, 64'd1, 6'd15); idle(36);
    drive(4'd14, 64'h0000_0000_FFFF_FF9C, 64'hABCD_0000_0000_0007, 6'd16); idle(36);
    drive(4'd15, 64'h0000_0000_FFFF_FFFF, 64'd16, 6'd17); idle(36);
    // R7: zero divisors
    drive(4'd8, 64'd55, 64'd0, 6'd20);      idle(70);
    drive(4'd11, 64'd55, 64'd0, 6'd21);     idle(70);
    drive(4'd14, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_0000_0000, 6'd22); idle(36);
    // R8: overflow at both widths
    drive(4'd8, MIN64, '1, 6'd23);          idle(70);
    drive(4'd10, MIN64, '1, 6'd24);         idle(70);
    drive(4'd12, 64'h0000_0000_8000_0000, '1, 6'd25); idle(36);
    drive(4'd14, 64'h0000_0000_8000_0000, '1, 6'd26); idle(36);

    // R10: requests during busy are dropped
    drive(4'd12, 64'd1000, 64'd9, 6'd30);
    drive(4'd0, 64'd3, 64'd4, 6'd31);
    idle(5);
    drive(4'd8, 64'd5, 64'd1, 6'd32);
    idle(35);

    // R11: flush at several depths
    drive(4'd0, 64'd9, 64'd9, 6'd40);
    drive(4'd0, 64'd8, 64'd8, 6'd41);
    pulse_flush();
    idle(5);
    drive(4'd9, 64'd100, 64'd3, 6'd42);
    idle(20);
    pulse_flush();
    idle(70);
    in_valid = 1'b1; in_op = 4'd0; in_a = 64'd2; in_b = 64'd2; in_tag = 6'd43;
    pulse_flush();
    idle(8);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 50 == 0) pulse_flush();
      else if ($urandom % 4 == 0) idle(1 + $urandom % 3);
      else drive(pick_op(), pick(), pick(), 6'($urandom));
    end
    idle(80);
    finish_run();
  end

endmodule